// File: doc/BRIEF.md
# I2C Command Target with Busy Refusal

This block is the serial front end of a coprocessor-style device on a two-wire bus. It watches oversampled clock and data lines. It finds START, repeated START and STOP conditions and matches its own 7-bit address. It answers each byte in the ninth clock slot by pulling the data line low or by leaving it released. The core supplies a busy flag. While that flag is high, the block will not answer its own address, so a controller sees the device as absent until the core is ready again.

A write access begins with a command code, which an external lookup classifies. An unknown code is refused, and so is everything after it in the same access. A known code either names an implied register pointer, or asks for a pointer byte as the next byte. Any remaining bytes are written into a byte-wide register file, and the pointer advances after each one. A read access returns register file bytes from the current pointer. The pointer is left over from the last write access or from the last pointer-implying command. Each controller acknowledge moves the pointer on by one, and the pointer wraps at the end of the file.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, and after any STOP, the block leaves SDA released (`sda_oe_o` = 0) and issues no register file write.
- R2: A byte whose upper seven bits equal `ADDR` is acknowledged when `busy_i` is low: SDA is held low for the whole high phase of the ninth clock. Bit 0 of that byte selects the access type: 0 for write, 1 for read.
- R3: When `busy_i` is high while its own address byte completes, the block leaves SDA released in the acknowledge slot. It then answers no further byte until a new START.
- R4: A byte with a different address is not acknowledged, and the rest of that access is ignored.
- R5: In a write access, the first byte after the address is a command code presented on `cmd_code_o`. It is acknowledged when `cmd_valid_i` is high. If `cmd_ptr_en_i` is also high, the pointer is loaded from `cmd_ptr_i`.
- R6: An invalid command code is refused. Every later byte of the same access is refused too, and no register write happens.
- R7: After a valid command that does not imply a pointer, the next byte is a pointer value. It is accepted when it is below `DEPTH`, and refused when it is `DEPTH` or more.
- R8: Every further write byte is acknowledged and written to the register file at the pointer. The pointer then advances by one, and from `DEPTH`-1 it wraps to 0.
- R9: In a read access, bytes are sent MSB first, starting at the current pointer. The pointer advances, with the same wrap, after each byte that the controller acknowledges.
- R10: After a controller NACK in a read, the block releases SDA and sends nothing more until a new START.
- R11: `sda_oe_o` changes only while SCL is low: one system clock after the synchronized SCL falling edge is detected.
- R12: A START or a STOP in the middle of a byte aborts that byte without side effects. A START goes straight to address matching; a STOP returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| busy_i | input | 1 | Core busy; the block refuses its address while high |
| cmd_code_o | output | 8 | Received byte, presented to the command lookup |
| cmd_valid_i | input | 1 | Lookup result: the command code is known |
| cmd_ptr_en_i | input | 1 | Lookup result: the command implies a pointer |
| cmd_ptr_i | input | AW | Implied pointer value |
| rf_addr_o | output | AW | Register file address (current pointer) |
| rf_wdata_o | output | 8 | Register file write data |
| rf_we_o | output | 1 | Register file write strobe, one clock |
| rf_rdata_i | input | 8 | Register file read data for `rf_addr_o`, combinational |

## Verification
The hardest situations to reach are the ones where the block must stay silent after it has started an access. These include refusal after an acknowledged address, reads that continue past a controller NACK, and START or STOP arriving partway through a byte. The bench reaches them with a bit-level bus controller that can stop after any number of clock pulses and insert a repeated START or a STOP there. It then reads the register file back through a fresh read access, which shows that an aborted or refused byte left neither a write nor a pointer change behind. A queue of expected register writes is compared on every clock, so any stray write strobe is reported at once.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    WS_CMD,
    WS_PTR,
    WS_DATA
  } wr_step_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic         scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_d  <= scl_ff[MSB];
      sda_d  <= sda_ff[MSB];
    end
  end

  assign scl_o      = scl_ff[MSB];
  assign sda_o      = sda_ff[MSB];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // conditions only count while SCL stays high over both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (inc_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  a_r8_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o == LAST) |=> (ptr_o == '0));

  a_r9_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + 1'b1));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] ADDR  = 7'h2A,
  parameter int         DEPTH = 32,
  localparam int        AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          busy_i,
  output logic [7:0]    cmd_code_o,
  input  logic          cmd_valid_i,
  input  logic          cmd_ptr_en_i,
  input  logic [AW-1:0] cmd_ptr_i,
  output logic          ptr_load_o,
  output logic [AW-1:0] ptr_val_o,
  output logic          ptr_inc_o,
  output logic          rf_we_o,
  output logic [7:0]    rf_wdata_o,
  input  logic [7:0]    rf_rdata_i,
  output logic          sda_oe_o
);
  tgt_state_e state_q;
  wr_step_e   step_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] rx_sh_q, tx_sh_q;
  logic       is_addr_q, rd_mode_q, ack_q, mack_q, sda_oe_q;

  logic evt_ok, byte_done, addr_hit, ptr_in_range, ack_ok;

  assign evt_ok       = !start_i && !stop_i;
  assign byte_done    = evt_ok && state_q == ST_RX && scl_fall_i && bit_cnt_q == 4'd8;
  assign addr_hit     = rx_sh_q[7:1] == ADDR;
  assign ptr_in_range = int'(rx_sh_q) < DEPTH;

  always_comb begin
    if (is_addr_q) begin
      ack_ok = addr_hit && !busy_i;
    end else begin
      unique case (step_q)
        WS_CMD:  ack_ok = cmd_valid_i;
        WS_PTR:  ack_ok = ptr_in_range;
        default: ack_ok = 1'b1;
      endcase
    end
  end

  assign cmd_code_o = rx_sh_q;
  assign rf_wdata_o = rx_sh_q;
  assign rf_we_o    = byte_done && !is_addr_q && step_q == WS_DATA;
  assign ptr_load_o = byte_done && !is_addr_q &&
                      ((step_q == WS_CMD && cmd_valid_i && cmd_ptr_en_i) ||
                       (step_q == WS_PTR && ptr_in_range));
  assign ptr_val_o  = (step_q == WS_CMD) ? cmd_ptr_i : rx_sh_q[AW-1:0];
  // controller ACK is sampled on the rising edge of its slot
  assign ptr_inc_o  = rf_we_o ||
                      (evt_ok && state_q == ST_MACK && scl_rise_i && !sda_s_i);
  assign sda_oe_o   = sda_oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= WS_CMD;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      is_addr_q <= 1'b0;
      rd_mode_q <= 1'b0;
      ack_q     <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_RX;
      bit_cnt_q <= '0;
      is_addr_q <= 1'b1;
      sda_oe_q  <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_s_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
            ack_q    <= ack_ok;
            sda_oe_q <= ack_ok;
            state_q  <= ST_ACK;
            if (is_addr_q) begin
              rd_mode_q <= rx_sh_q[0];
              step_q    <= WS_CMD;
            end else if (ack_ok && step_q == WS_CMD) begin
              step_q <= cmd_ptr_en_i ? WS_DATA : WS_PTR;
            end else if (ack_ok && step_q == WS_PTR) begin
              step_q <= WS_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            is_addr_q <= 1'b0;
            bit_cnt_q <= '0;
            if (!ack_q) begin
              state_q  <= ST_IGNORE;
              sda_oe_q <= 1'b0;
            end else if (rd_mode_q) begin
              tx_sh_q  <= rf_rdata_i;
              sda_oe_q <= ~rf_rdata_i[7];
              state_q  <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bit_cnt_q == 4'd8) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_MACK;
            end else begin
              tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
              sda_oe_q <= ~tx_sh_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_s_i;
          end else if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (mack_q) begin
              tx_sh_q  <= rf_rdata_i;
              sda_oe_q <= ~rf_rdata_i[7];
              state_q  <= ST_TX;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r3_busy_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && is_addr_q && busy_i) |=> !sda_oe_o);

  a_r10_ignore_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> (!sda_oe_o && !rf_we_o && !ptr_inc_o));

  a_r11_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> !scl_s_i);

  a_r12_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_o && state_q == ST_IDLE));
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter logic [6:0] ADDR        = 7'h2A,
  parameter int         DEPTH       = 32,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          busy_i,
  output logic [7:0]    cmd_code_o,
  input  logic          cmd_valid_i,
  input  logic          cmd_ptr_en_i,
  input  logic [AW-1:0] cmd_ptr_i,
  output logic [AW-1:0] rf_addr_o,
  output logic [7:0]    rf_wdata_o,
  output logic          rf_we_o,
  input  logic [7:0]    rf_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_val, ptr;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_tgt_ctrl #(.ADDR(ADDR), .DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scl_s_i      (scl_s),
    .sda_s_i      (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_evt),
    .stop_i       (stop_evt),
    .busy_i       (busy_i),
    .cmd_code_o   (cmd_code_o),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ptr_en_i (cmd_ptr_en_i),
    .cmd_ptr_i    (cmd_ptr_i),
    .ptr_load_o   (ptr_load),
    .ptr_val_o    (ptr_val),
    .ptr_inc_o    (ptr_inc),
    .rf_we_o      (rf_we_o),
    .rf_wdata_o   (rf_wdata_o),
    .rf_rdata_i   (rf_rdata_i),
    .sda_oe_o     (sda_oe_o)
  );

  i2c_tgt_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .inc_i      (ptr_inc),
    .ptr_o      (ptr)
  );

  assign rf_addr_o = ptr;
endmodule

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;
  localparam int         Q     = 10;
  localparam int         DEPTH = 32;
  localparam int         AW    = 5;
  localparam logic [7:0] AWR   = 8'h54;  // address 0x2A, write
  localparam logic [7:0] ARD   = 8'h55;  // address 0x2A, read

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, m_scl_low, m_sda_low, busy;
  logic sda_oe, cmd_valid, cmd_ptr_en, rf_we;
  logic [7:0] cmd_code, rf_wdata, rf_rdata;
  logic [AW-1:0] cmd_ptr, rf_addr;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  wire scl_line = !m_scl_low;
  wire sda_line = !(m_sda_low || sda_oe);

  int checks = 0, errors = 0, r11_viol = 0, hi_cnt = 0;
  logic prev_oe = 1'b0;
  int exp_wr[$];

  i2c_cmd_target u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .cmd_code_o(cmd_code),
    .cmd_valid_i(cmd_valid), .cmd_ptr_en_i(cmd_ptr_en), .cmd_ptr_i(cmd_ptr),
    .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rf_we_o(rf_we),
    .rf_rdata_i(rf_rdata)
  );

  // command table: 0x10 wants a pointer byte, 0x20 implies 5, 0x21 implies 31
  assign cmd_valid  = cmd_code inside {8'h10, 8'h20, 8'h21};
  assign cmd_ptr_en = cmd_code[5];
  assign cmd_ptr    = (cmd_code == 8'h21) ? 5'd31 : 5'd5;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 1);
    end else if (rf_we) begin
      mem[rf_addr] <= rf_wdata;
    end
  end
  assign rf_rdata = mem[rf_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock monitor: write strobes against expected queue, R11 timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt > 4 && sda_oe != prev_oe) r11_viol++;
      prev_oe = sda_oe;
      if (rf_we) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R6 unexpected write", int'({rf_addr, rf_wdata}), 0);
        end else begin
          int e;
          e = exp_wr.pop_front();
          chk(e == int'({rf_addr, rf_wdata}), "R8 write addr/data",
              int'({rf_addr, rf_wdata}), e);
        end
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input bit drive_low, output bit s);
    m_scl_low = 1'b1; wq();
    m_sda_low = drive_low; wq();
    m_scl_low = 1'b0; wq();
    s = sda_line; wq();
  endtask

  task automatic i_start();
    m_scl_low = 1'b1; wq();
    m_sda_low = 1'b0; wq();
    m_scl_low = 1'b0; wq();
    m_sda_low = 1'b1; wq();
  endtask

  task automatic i_stop();
    m_scl_low = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl_low = 1'b0; wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic w(input logic [7:0] b, input bit exp_ack, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(!b[i], s);
    clock_bit(1'b0, s);
    chk(!s == exp_ack, req, int'(!s), int'(exp_ack));
  endtask

  task automatic r(input bit nack, input logic [7:0] exp, input string req);
    bit s;
    logic [7:0] b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b0, s);
      b = {b[6:0], s};
    end
    clock_bit(!nack, s);
    chk(b == exp, req, int'(b), int'(exp));
  endtask

  task automatic exp_write(input int a, input logic [7:0] d);
    exp_wr.push_back((a << 8) | int'(d));
    exp_mem[a] = d;
  endtask

  task automatic bits(input int n);
    bit s;
    for (int i = 0; i < n; i++) clock_bit(1'b0, s);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'(i * 7 + 1);
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0; busy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset release", int'(sda_oe), 0);
    chk(rf_we == 1'b0, "R1 reset no write", int'(rf_we), 0);

    // write via pointer byte
    i_start();
    w(AWR, 1, "R2 address write ack");
    w(8'h10, 1, "R5 valid command ack");
    w(8'h03, 1, "R7 pointer byte ack");
    exp_write(3, 8'hA1); w(8'hA1, 1, "R8 data ack");
    exp_write(4, 8'hB2); w(8'hB2, 1, "R8 data ack");
    exp_write(5, 8'hC3); w(8'hC3, 1, "R8 data ack");
    i_stop();
    chk(sda_oe == 1'b0, "R1 idle after stop", int'(sda_oe), 0);

    // read back with pointer from preceding write
    i_start();
    w(AWR, 1, "R2 address"); w(8'h10, 1, "R5 cmd"); w(8'h03, 1, "R7 ptr");
    i_start();
    w(ARD, 1, "R2 address read ack");
    r(0, exp_mem[3], "R9 read first");
    r(0, exp_mem[4], "R9 read second");
    r(1, exp_mem[5], "R10 last before nack");
    r(1, 8'hFF, "R10 released after nack");
    i_stop();

    // busy refuses address
    busy = 1'b1;
    i_start();
    w(AWR, 0, "R3 busy address nack");
    w(8'h10, 0, "R3 byte after refusal");
    i_stop();
    busy = 1'b0;

    // other address
    i_start();
    w(8'h56, 0, "R4 foreign address");
    w(8'h10, 0, "R4 ignored byte");
    i_stop();

    // invalid command
    i_start();
    w(AWR, 1, "R6 address still acked");
    w(8'h77, 0, "R6 invalid command nack");
    w(8'h12, 0, "R6 later byte nack");
    i_stop();

    // pointer out of range (DEPTH itself)
    i_start();
    w(AWR, 1, "R7 address"); w(8'h10, 1, "R7 cmd");
    w(8'd32, 0, "R7 pointer equal DEPTH nack");
    w(8'h99, 0, "R7 byte after refused pointer");
    i_stop();

    // implied pointer 31, write wraps to 0
    i_start();
    w(AWR, 1, "R5 address"); w(8'h21, 1, "R5 implied-pointer cmd");
    exp_write(31, 8'hD0); w(8'hD0, 1, "R8 write at last");
    exp_write(0, 8'hE1);  w(8'hE1, 1, "R8 write after wrap");
    i_start();
    w(AWR, 1, "R5 address"); w(8'h21, 1, "R5 cmd");
    i_start();
    w(ARD, 1, "R9 address read");
    r(0, exp_mem[31], "R9 read at last");
    r(1, exp_mem[0], "R9 read wrapped");
    i_stop();

    // command 0x20 implies pointer 5
    i_start();
    w(AWR, 1, "R5 address"); w(8'h20, 1, "R5 cmd 0x20");
    i_start();
    w(ARD, 1, "R5 address read");
    r(1, exp_mem[5], "R5 implied pointer read");
    i_stop();

    // START in mid-byte
    i_start();
    w(AWR, 1, "R12 address"); w(8'h10, 1, "R12 cmd"); w(8'h08, 1, "R12 ptr");
    bits(4);
    i_start();
    w(ARD, 1, "R12 address after abort");
    r(1, exp_mem[8], "R12 aborted byte left no write");
    i_stop();

    // STOP in mid-byte
    i_start();
    w(AWR, 1, "R12 address");
    bits(3);
    i_stop();
    chk(sda_oe == 1'b0, "R12 idle after mid-byte stop", int'(sda_oe), 0);
    i_start();
    w(AWR, 1, "R12 recovers after stop");
    i_stop();

    repeat (20) @(negedge clk);
    chk(r11_viol == 0, "R11 sda change while scl high", r11_viol, 0);
    chk(exp_wr.size() == 0, "R8 missing writes", exp_wr.size(), 0);
    finish_run();
  end
endmodule